// File: doc/BRIEF.md
# Switch Time-Code Distribution Unit

This block is the central time-keeping point of a multi-port packet switch. Any port may hand it an 8-bit time-code with a one-cycle strobe. The code carries a 6-bit count in bits [5:0] and two control flags in bits [7:6]. The unit holds a master count and its flags, and judges each arriving code against that count. A code whose count is the stored count plus one, modulo 64, is valid. A valid code is sent out as a one-cycle strobe, with the code value, to every other port that has time-codes enabled.

A filter switch can restrict acceptance to codes whose flags are both zero. Each port has its own enable bit, and a global disable input stops all time-code traffic. When several ports offer codes in the same cycle, each code is held in a per-port pending slot. The slots are then drained one per cycle, lowest port index first. The stored count and flags are always visible on a status output, packed as {flags, count}.

A strobe on a tick input is captured at the next clock edge. The resulting output strobe appears one edge later, so the latency is two cycles from input strobe to output strobe.

Top module: `tc_dist`

## Requirements
- R1: After reset, `time_stat` is 0 (count and flags both zero) and every `tick_out` bit is 0.
- R2: An accepted code is valid when its count (bits [5:0]) equals the stored count plus one, modulo 64. A valid code drives `tick_out` high for exactly one cycle, two cycles after its input strobe, on every enabled port except its source. The code value is placed on `code_out` of each strobed port.
- R3: The port a code came from never receives that code back, so at most NP-1 `tick_out` bits are high in any cycle.
- R4: Every accepted code loads its count and flags into the stored state, even when it is invalid. An invalid code produces no output strobe.
- R5: Validity wraps: with a stored count of 63, a code with count 0 is valid.
- R6: With `filt_en` low, the flags (bits [7:6]) do not affect acceptance or validity. With `filt_en` high, a code with nonzero flags is dropped: no strobe, and the stored state is unchanged.
- R7: A port whose `port_en` bit is 0 has its input codes ignored (stored state unchanged) and receives no output strobes.
- R8: While `tc_off` is high, no code is accepted, the stored state is unchanged, and all `tick_out` bits stay 0.
- R9: Codes arriving on several ports in the same cycle are processed one per cycle in ascending port order.
- R10: `time_stat` always shows the stored {flags, count}. While a strobe is out, it equals the forwarded code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | NP | Per-port incoming time-code strobe |
| code_in | input | NP*8 | Per-port incoming code, port i in bits [8i+7:8i] |
| port_en | input | NP | Per-port time-code enable (the system default is all ones) |
| filt_en | input | 1 | Accept only codes whose flags are zero |
| tc_off | input | 1 | Global time-code disable |
| tick_out | output | NP | Per-port outgoing one-cycle strobe |
| code_out | output | NP*8 | Per-port outgoing code, same packing as code_in |
| time_stat | output | 8 | Stored {flags[7:6], count[5:0]} |

## Verification
The assertions assume that `port_en`, `filt_en` and `tc_off` are driven to known values from the first clock after reset. They also assume that a strobe on `tick_in` comes with a stable code in the same cycle. The bench changes inputs only on the falling edge. It holds the control inputs steady for the length of each transfer, so the expected output strobe and status can be tied to one known configuration. Random trials mix valid and invalid counts, nonzero flags, disabled ports and the global disable. Directed cases cover the modulo-64 wrap and codes offered on several ports at once.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_CNT_W = 6;
  localparam int TC_FLG_W = 2;
  localparam int TC_CODE_W = TC_CNT_W + TC_FLG_W;
endpackage

// File: rtl/tc_capture.sv
module tc_capture #(
  parameter int NP = 4,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NP-1:0]  tick_in,
  input  logic [NP*CW-1:0] code_in,
  input  logic [NP-1:0]  port_en,
  input  logic           tc_off,
  input  logic [NP-1:0]  grant,
  output logic [NP-1:0]  pend,
  output logic [NP*CW-1:0] pcode
);
  for (genvar i = 0; i < NP; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[i] <= 1'b0;
        pcode[i*CW +: CW] <= '0;
      end else if (tc_off || !port_en[i]) begin
        pend[i] <= 1'b0;
      end else if (tick_in[i]) begin
        pend[i] <= 1'b1;
        pcode[i*CW +: CW] <= code_in[i*CW +: CW];
      end else if (grant[i]) begin
        pend[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tc_pick.sv
module tc_pick #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0] pend,
  output logic          any,
  output logic [NP-1:0] grant,
  output logic [IW-1:0] idx
);
  always_comb begin
    any   = 1'b0;
    grant = '0;
    idx   = '0;
    for (int i = 0; i < NP; i++) begin
      if (pend[i] && !any) begin
        any      = 1'b1;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tc_core.sv
module tc_core #(
  parameter int NP   = 4,
  parameter int CNTW = 6,
  parameter int FLGW = 2,
  localparam int CW  = CNTW + FLGW,
  localparam int IW  = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any,
  input  logic [IW-1:0]    idx,
  input  logic [NP*CW-1:0] pcode,
  input  logic [NP-1:0]    port_en,
  input  logic             tc_off,
  input  logic             filt_en,
  output logic [NP-1:0]    tick_out,
  output logic [NP*CW-1:0] code_out,
  output logic [CW-1:0]    time_stat
);
  logic [CW-1:0]   sel;
  logic [CNTW-1:0] nxt_cnt;
  logic            accept;
  logic            valid;
  logic [NP-1:0]   others;

  assign sel     = pcode[idx*CW +: CW];
  assign nxt_cnt = time_stat[CNTW-1:0] + 1'b1;
  assign accept  = any && !tc_off && !(filt_en && (sel[CW-1:CNTW] != '0));
  assign valid   = accept && (sel[CNTW-1:0] == nxt_cnt);
  assign others  = ~(NP'(1) << idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_stat <= '0;
      tick_out  <= '0;
      code_out  <= '0;
    end else begin
      tick_out <= valid ? (port_en & others) : '0;
      if (accept) time_stat <= sel;
      if (valid) code_out <= {NP{sel}};
    end
  end
endmodule

// File: rtl/tc_dist.sv
module tc_dist #(
  parameter int NP   = 4,
  parameter int CNTW = tc_pkg::TC_CNT_W,
  parameter int FLGW = tc_pkg::TC_FLG_W,
  localparam int CW  = CNTW + FLGW,
  localparam int IW  = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    tick_in,
  input  logic [NP*CW-1:0] code_in,
  input  logic [NP-1:0]    port_en,
  input  logic             filt_en,
  input  logic             tc_off,
  output logic [NP-1:0]    tick_out,
  output logic [NP*CW-1:0] code_out,
  output logic [CW-1:0]    time_stat
);
  logic [NP-1:0]    pend;
  logic [NP*CW-1:0] pcode;
  logic [NP-1:0]    grant;
  logic             any;
  logic [IW-1:0]    idx;

  tc_capture #(.NP(NP), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .tick_in(tick_in), .code_in(code_in),
    .port_en(port_en), .tc_off(tc_off), .grant(grant),
    .pend(pend), .pcode(pcode)
  );

  tc_pick #(.NP(NP)) u_pick (
    .pend(pend), .any(any), .grant(grant), .idx(idx)
  );

  tc_core #(.NP(NP), .CNTW(CNTW), .FLGW(FLGW)) u_core (
    .clk(clk), .rst(rst), .any(any), .idx(idx), .pcode(pcode),
    .port_en(port_en), .tc_off(tc_off), .filt_en(filt_en),
    .tick_out(tick_out), .code_out(code_out), .time_stat(time_stat)
  );
endmodule

// File: rtl/tc_dist_chk.sv
module tc_dist_chk #(
  parameter int NP   = 4,
  parameter int CNTW = 6,
  parameter int FLGW = 2,
  localparam int CW  = CNTW + FLGW
) (
  input logic             clk,
  input logic             rst,
  input logic             tc_off,
  input logic             filt_en,
  input logic [NP-1:0]    port_en,
  input logic [NP-1:0]    tick_out,
  input logic [NP*CW-1:0] code_out,
  input logic [CW-1:0]    time_stat
);
  a_r3_src_excluded: assert property (@(posedge clk) disable iff (rst)
    $countones(tick_out) < NP);

  a_r2_r5_step_valid: assert property (@(posedge clk) disable iff (rst)
    (tick_out != '0) |-> (time_stat[CNTW-1:0] == CNTW'($past(time_stat[CNTW-1:0]) + 1'b1)));

  a_r6_filter_flags: assert property (@(posedge clk) disable iff (rst)
    ((tick_out != '0) && $past(filt_en)) |-> (time_stat[CW-1:CNTW] == '0));

  a_r8_global_off: assert property (@(posedge clk) disable iff (rst)
    tc_off |=> (tick_out == '0));

  a_r7_port_off: assert property (@(posedge clk) disable iff (rst)
    (port_en != '1) |=> ((tick_out & ~$past(port_en)) == '0));

  for (genvar i = 0; i < NP; i++) begin : g_chk
    a_r10_code_match: assert property (@(posedge clk) disable iff (rst)
      tick_out[i] |-> (code_out[i*CW +: CW] == time_stat));
  end
endmodule

bind tc_dist tc_dist_chk #(.NP(NP), .CNTW(CNTW), .FLGW(FLGW)) u_chk (
  .clk(clk), .rst(rst), .tc_off(tc_off), .filt_en(filt_en), .port_en(port_en),
  .tick_out(tick_out), .code_out(code_out), .time_stat(time_stat)
);

// File: tb/test_tc_dist.sv
module test_tc_dist;
  localparam int NP = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    tick_in = '0;
  logic [NP*CW-1:0] code_in = '0;
  logic [NP-1:0]    port_en = '1;
  logic             filt_en = 1'b0;
  logic             tc_off = 1'b0;
  logic [NP-1:0]    tick_out;
  logic [NP*CW-1:0] code_out;
  logic [CW-1:0]    time_stat;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_stat = 8'h00;

  always #4 clk = ~clk;

  tc_dist #(.NP(NP)) i_tc_dist (
    .clk(clk), .rst(rst), .tick_in(tick_in), .code_in(code_in),
    .port_en(port_en), .filt_en(filt_en), .tc_off(tc_off),
    .tick_out(tick_out), .code_out(code_out), .time_stat(time_stat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic bit f_accept(input int p, input logic [7:0] c);
    return !tc_off && port_en[p] && !(filt_en && c[7:6] != 2'b00);
  endfunction

  function automatic bit f_valid(input logic [7:0] st, input logic [7:0] c);
    return c[5:0] == 6'((st[5:0] + 6'd1) & 6'h3F);
  endfunction

  task automatic send_one(input int p, input logic [7:0] c, input string req);
    logic [NP-1:0] exp_mask;
    logic [7:0] exp_stat;
    bit acc;
    acc = f_accept(p, c);
    exp_mask = (acc && f_valid(m_stat, c)) ? (port_en & ~(NP'(1) << p)) : '0;
    exp_stat = acc ? c : m_stat;
    @(negedge clk);
    tick_in = NP'(1) << p;
    code_in[p*CW +: CW] = c;
    @(negedge clk);
    tick_in = '0;
    @(negedge clk);
    chk(tick_out == exp_mask, {req, " strobe mask"}, 32'(tick_out), 32'(exp_mask));
    chk(time_stat == exp_stat, {req, " R10 status"}, 32'(time_stat), 32'(exp_stat));
    for (int i = 0; i < NP; i++)
      if (exp_mask[i])
        chk(code_out[i*CW +: CW] == c, {req, " R2 code value"}, 32'(code_out[i*CW +: CW]), 32'(c));
    m_stat = exp_stat;
    @(negedge clk);
    chk(tick_out == '0, {req, " R2 one-cycle strobe"}, 32'(tick_out), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(time_stat == 8'h00, "R1 reset status", 32'(time_stat), 32'h0);
    chk(tick_out == '0, "R1 reset strobes", 32'(tick_out), 32'h0);

    send_one(0, 8'h01, "R2 valid from port0");
    send_one(1, 8'h05, "R4 invalid updates count");
    send_one(2, 8'h3F, "R4 invalid load 63");
    send_one(3, 8'h00, "R5 wrap 63 to 0");
    send_one(1, 8'h81, "R6 filter off flags ignored");
    filt_en = 1'b1;
    send_one(2, 8'h42, "R6 filter drops flags");
    send_one(2, 8'h02, "R6 filter passes zero flags");
    filt_en = 1'b0;
    port_en = 4'b1011;
    send_one(2, 8'h03, "R7 disabled source ignored");
    send_one(0, 8'h03, "R7 disabled port no strobe");
    port_en = '1;
    tc_off = 1'b1;
    send_one(1, 8'h04, "R8 global disable");
    tc_off = 1'b0;

    // R9: three ports at once, drained lowest first
    begin
      logic [5:0] s;
      s = m_stat[5:0];
      @(negedge clk);
      tick_in = 4'b1110;
      code_in[1*CW +: CW] = {2'b00, 6'(s + 6'd1)};
      code_in[2*CW +: CW] = {2'b00, 6'(s + 6'd2)};
      code_in[3*CW +: CW] = {2'b00, 6'(s + 6'd3)};
      @(negedge clk);
      tick_in = '0;
      for (int k = 1; k <= 3; k++) begin
        logic [NP-1:0] em;
        em = ~(NP'(1) << k);
        @(negedge clk);
        chk(tick_out == em, "R9 ascending order mask", 32'(tick_out), 32'(em));
        chk(time_stat[5:0] == 6'(s + 6'(k)), "R9 ascending order count",
            32'(time_stat), 32'(6'(s + 6'(k))));
      end
      @(negedge clk);
      chk(tick_out == '0, "R9 drained", 32'(tick_out), 32'h0);
      m_stat = {2'b00, 6'(s + 6'd3)};
    end

    for (int t = 0; t < 400; t++) begin
      int p;
      logic [7:0] c;
      p = int'($urandom % NP);
      port_en = ($urandom % 4 == 0) ? NP'($urandom) : '1;
      filt_en = 1'($urandom % 2);
      tc_off = ($urandom % 8 == 0);
      c[5:0] = ($urandom % 2 == 1) ? 6'(m_stat[5:0] + 6'd1) : 6'($urandom);
      c[7:6] = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      send_one(p, c, "R3 R4 R6 R7 R8 random");
    end
    port_en = '1;
    tc_off = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule